// File: doc/BRIEF.md
# Auto-Reload Timer Baud Generator

This block is a 16-bit up-counting timer that supplies bit clocks to the transmit and receive shifters of a UART. When it overflows, the counter reloads from a 16-bit reload register. Each overflow then feeds a per-direction divide-by-16 whose terminal count produces a one-cycle bit-clock tick. The receive side and the transmit side each have their own select input. When a select is high, that direction takes its ticks from this timer. When it is low, the direction uses an alternate overflow pulse that arrives from outside the block. That pulse is halved unless the double-rate input is high.

The timer is in baud mode while either select is high. In baud mode it counts every second system clock, or on falling edges of an external count pin. It always auto-reloads and never raises its overflow flag. Outside baud mode the timer is a plain 16-bit timer that counts every system clock, and it raises an overflow flag on overflow. In that mode it can also run in capture mode: an overflow wraps the counter to zero, and a trigger edge copies the counter into the reload register. In every mode, a falling edge on the trigger pin sets an external flag when the external enable input is high. Both flags can request an interrupt.

Top module: `reload_baud_timer`

## Requirements
- R1: Outside capture mode, an advance at count 0xFFFF loads the reload register value into the counter on that clock edge.
- R2: While `rxClkSel` or `txClkSel` is 1, an overflow never sets `ovfFlag`.
- R3: `rxClkSel` routes this timer's overflows to the receive divider and `txClkSel` routes them to the transmit divider, each independently; a direction whose select is 0 uses the alternate path.
- R4: While either select is 1, an overflow reloads the counter even when `captureMode` is 1, and trigger edges never change `reload`.
- R5: In baud mode with `extCountSel` = 0 and `run` = 1, the counter advances on every second clock, first on the second clock after run starts; with neither select set it advances every clock.
- R6: With `extCountSel` = 1, each falling edge of `cntPin` advances the counter once; the pin passes through a two-flop synchronizer and one edge-detect register, so the advance lands on the third clock edge after the pin falls.
- R7: Each direction counts its source pulses modulo 16; on the 16th pulse, the tick output goes high for exactly one clock, on the clock after that pulse.
- R8: With a select at 0, only every second `altOvf` pulse reaches that divider (the 2nd, 4th, and so on after reset); with `doubleRate` = 1 every pulse reaches it.
- R9: With `extEnable` = 1, a synchronized falling edge on `trigPin` sets `extFlag` in any mode; `irq` is high whenever `irqEn` = 1 and either flag is set.
- R10: With `run` = 0 the counter holds its value and no overflow occurs.
- R11: Reset clears `count`, `reload`, both flags and both ticks. A write to the counter or to the reload register takes effect on the next clock and overrides an advance or a capture in the same cycle. A set of a flag overrides a clear in the same cycle.
- R12: Outside baud mode, an overflow sets `ovfFlag`. With `captureMode` = 1 the overflow wraps the counter to 0, and a trigger edge with `extEnable` = 1 copies the counter into `reload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run control |
| extCountSel | input | 1 | 1: count falling edges of cntPin |
| rxClkSel | input | 1 | Receive ticks from this timer |
| txClkSel | input | 1 | Transmit ticks from this timer |
| captureMode | input | 1 | Capture instead of reload (non-baud only) |
| extEnable | input | 1 | Enable trigger pin edge detection |
| doubleRate | input | 1 | Bypass halving of the alternate pulse |
| irqEn | input | 1 | Interrupt enable |
| cntPin | input | 1 | External count pin (asynchronous) |
| trigPin | input | 1 | External trigger pin (asynchronous) |
| altOvf | input | 1 | Alternate timer overflow pulse |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 16 | Counter write value |
| rldWrEn | input | 1 | Reload register write strobe |
| rldWrData | input | 16 | Reload write value |
| ovfClr | input | 1 | Clear ovfFlag |
| extClr | input | 1 | Clear extFlag |
| count | output | 16 | Counter value |
| reload | output | 16 | Reload/capture register |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | Trigger edge flag |
| irq | output | 1 | Interrupt request |
| rxTick | output | 1 | Receive bit-clock tick |
| txTick | output | 1 | Transmit bit-clock tick |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 4-bit divider and two synchronizer stages. That makes the divide-by-16 and the exact synchronizer latency of R6 directly observable. Reload values just below 0xFFFF, together with counter writes near the top, bring many overflows within a few hundred cycles at full width. Ticks in both directions, capture wrap-around and the baud-mode halving of the count rate therefore all occur many times within a short run.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef struct packed {
    logic advance;      // counter steps this cycle
    logic reloadOnOvf;  // overflow reloads instead of wrapping
    logic capture;      // copy counter into reload register
    logic extEdge;      // qualified trigger falling edge
    logic baudMode;     // either clock select active
    logic altPass;      // alternate pulse after optional halving
  } ctrlStrobes_t;
endpackage

// File: rtl/rbt_ctrl.sv
module rbt_ctrl
  import rbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         extCountSel,
  input  logic         rxClkSel,
  input  logic         txClkSel,
  input  logic         captureMode,
  input  logic         extEnable,
  input  logic         doubleRate,
  input  logic         cntPin,
  input  logic         trigPin,
  input  logic         altOvf,
  output ctrlStrobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cntSync, trigSync;
  logic cntPrev, trigPrev, halfPhase, altHalf;
  logic cntFall, trigFall, baud;

  // two-flop (or deeper) synchronizers followed by one edge-detect register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntSync  <= '0;
      trigSync <= '0;
      cntPrev  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      cntSync  <= {cntSync[LAST-1:0], cntPin};
      trigSync <= {trigSync[LAST-1:0], trigPin};
      cntPrev  <= cntSync[LAST];
      trigPrev <= trigSync[LAST];
    end
  end

  assign cntFall  = cntPrev & ~cntSync[LAST];
  assign trigFall = trigPrev & ~trigSync[LAST];
  assign baud     = rxClkSel | txClkSel;

  // divide-by-two time base used only in baud mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           halfPhase <= 1'b0;
    else if (run && baud && !extCountSel) halfPhase <= ~halfPhase;
    else                                 halfPhase <= 1'b0;
  end

  // halving of the alternate overflow pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       altHalf <= 1'b0;
    else if (altOvf) altHalf <= ~altHalf;
  end

  always_comb begin
    strobes.baudMode    = baud;
    strobes.advance     = run & (extCountSel ? cntFall : (baud ? halfPhase : 1'b1));
    strobes.reloadOnOvf = baud | ~captureMode;
    strobes.extEdge     = extEnable & trigFall;
    strobes.capture     = ~baud & captureMode & extEnable & trigFall;
    strobes.altPass     = altOvf & (doubleRate | altHalf);
  end
endmodule

// File: rtl/rbt_datapath.sv
module rbt_datapath
  import rbt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             rldWrEn,
  input  logic [WIDTH-1:0] rldWrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] reload,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             ovfPulse
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic atTop;
  assign atTop    = (count == TOP);
  assign ovfPulse = strobes.advance & atTop & ~cntWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (cntWrEn)         count <= cntWrData;
    else if (strobes.advance) begin
      if (!atTop)                  count <= count + 1'b1;
      else if (strobes.reloadOnOvf) count <= reload;
      else                         count <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                reload <= '0;
    else if (rldWrEn)         reload <= rldWrData;
    else if (strobes.capture) reload <= count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (ovfPulse && !strobes.baudMode) ovfFlag <= 1'b1;
      else if (ovfClr)                   ovfFlag <= 1'b0;
      if (strobes.extEdge)               extFlag <= 1'b1;
      else if (extClr)                   extFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rbt_divider.sv
module rbt_divider #(
  parameter int DIV_BITS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcPulse,
  output logic tick
);
  localparam logic [DIV_BITS-1:0] LAST = '1;

  logic [DIV_BITS-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= srcPulse && (phase == LAST);
      if (srcPulse) phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/reload_baud_timer.sv
module reload_baud_timer
  import rbt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIV_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             extCountSel,
  input  logic             rxClkSel,
  input  logic             txClkSel,
  input  logic             captureMode,
  input  logic             extEnable,
  input  logic             doubleRate,
  input  logic             irqEn,
  input  logic             cntPin,
  input  logic             trigPin,
  input  logic             altOvf,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             rldWrEn,
  input  logic [WIDTH-1:0] rldWrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] reload,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             irq,
  output logic             rxTick,
  output logic             txTick
);
  ctrlStrobes_t strobes;
  logic ovfPulse;
  logic [1:0] dirSel, dirTick;

  rbt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .run(run), .extCountSel(extCountSel),
    .rxClkSel(rxClkSel), .txClkSel(txClkSel), .captureMode(captureMode),
    .extEnable(extEnable), .doubleRate(doubleRate), .cntPin(cntPin),
    .trigPin(trigPin), .altOvf(altOvf), .strobes(strobes)
  );

  rbt_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .rldWrEn(rldWrEn), .rldWrData(rldWrData),
    .ovfClr(ovfClr), .extClr(extClr),
    .count(count), .reload(reload), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .ovfPulse(ovfPulse)
  );

  assign dirSel = {txClkSel, rxClkSel};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic src;
    assign src = dirSel[d] ? ovfPulse : strobes.altPass;
    rbt_divider #(.DIV_BITS(DIV_BITS)) div_i (
      .clk(clk), .rstN(rstN), .srcPulse(src), .tick(dirTick[d])
    );
  end

  assign rxTick = dirTick[0];
  assign txTick = dirTick[1];
  assign irq    = irqEn & (ovfFlag | extFlag);
endmodule

module reload_baud_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             rxClkSel,
  input logic             txClkSel,
  input logic             extEnable,
  input logic             cntWrEn,
  input logic [WIDTH-1:0] cntWrData,
  input logic             rldWrEn,
  input logic [WIDTH-1:0] rldWrData,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] reload,
  input logic             ovfFlag,
  input logic             extFlag,
  input logic             rxTick,
  input logic             txTick
);
  // R2
  baud_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(!(rxClkSel || txClkSel)));
  // R7
  rx_tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |=> !rxTick);
  // R7
  tx_tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick |=> !txTick);
  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !cntWrEn) |=> $stable(count));
  // R11
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> count == $past(cntWrData));
  // R11
  rld_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rldWrEn |=> reload == $past(rldWrData));
  // R9
  ext_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFlag) |-> $past(extEnable));
  // R4
  baud_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxClkSel && !rldWrEn) |=> $stable(reload));
endmodule

bind reload_baud_timer reload_baud_timer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .run(run), .rxClkSel(rxClkSel), .txClkSel(txClkSel),
  .extEnable(extEnable), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
  .rldWrEn(rldWrEn), .rldWrData(rldWrData), .count(count), .reload(reload),
  .ovfFlag(ovfFlag), .extFlag(extFlag), .rxTick(rxTick), .txTick(txTick)
);

// File: tb/reload_baud_timer_tb.sv
module reload_baud_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic run = 0, extCountSel = 0, rxClkSel = 0, txClkSel = 0, captureMode = 0;
  logic extEnable = 0, doubleRate = 0, irqEn = 0, cntPin = 1, trigPin = 1, altOvf = 0;
  logic cntWrEn = 0, rldWrEn = 0, ovfClr = 0, extClr = 0;
  logic [W-1:0] cntWrData = '0, rldWrData = '0;
  logic [W-1:0] count, reload;
  logic ovfFlag, extFlag, irq, rxTick, txTick;
  int tests = 0, fails = 0;
  logic prevRx = 0, prevTx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_baud_timer dut_i (.*);

  // reference model state
  logic [1:0] mCs, mTs;
  logic mCp, mTp, mHalf, mAltHalf, mOvfF, mExtF;
  logic [W-1:0] mCnt, mRld;
  logic [3:0] mPh [2];
  logic [1:0] mTick;
  logic mBaud, mAdv, mOvf, mCap, mEdge, mAlt, mCf, mTf;
  logic [1:0] mSrc;

  function automatic logic advanceOf(logic r, logic es, logic b, logic h, logic cf);
    if (!r) return 1'b0;
    if (es) return cf;
    return b ? h : 1'b1;
  endfunction

  always_comb begin
    mCf    = mCp & ~mCs[1];
    mTf    = mTp & ~mTs[1];
    mBaud  = rxClkSel | txClkSel;
    mAdv   = advanceOf(run, extCountSel, mBaud, mHalf, mCf);
    mOvf   = mAdv & (mCnt == 16'hFFFF) & ~cntWrEn;
    mEdge  = extEnable & mTf;
    mCap   = ~mBaud & captureMode & mEdge;
    mAlt   = altOvf & (doubleRate | mAltHalf);
    mSrc[0] = rxClkSel ? mOvf : mAlt;
    mSrc[1] = txClkSel ? mOvf : mAlt;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCs <= 0; mTs <= 0; mCp <= 0; mTp <= 0; mHalf <= 0; mAltHalf <= 0;
      mCnt <= 0; mRld <= 0; mOvfF <= 0; mExtF <= 0; mTick <= 0;
      mPh[0] <= 0; mPh[1] <= 0;
    end else begin
      mCs <= {mCs[0], cntPin}; mTs <= {mTs[0], trigPin};
      mCp <= mCs[1]; mTp <= mTs[1];
      mHalf <= (run && mBaud && !extCountSel) ? ~mHalf : 1'b0;
      if (altOvf) mAltHalf <= ~mAltHalf;
      if (cntWrEn) mCnt <= cntWrData;
      else if (mAdv) mCnt <= (mCnt != 16'hFFFF) ? mCnt + 1 :
                             ((mBaud || !captureMode) ? mRld : '0);
      if (rldWrEn) mRld <= rldWrData;
      else if (mCap) mRld <= mCnt;
      if (mOvf && !mBaud) mOvfF <= 1; else if (ovfClr) mOvfF <= 0;
      if (mEdge) mExtF <= 1; else if (extClr) mExtF <= 0;
      for (int d = 0; d < 2; d++) begin
        mTick[d] <= mSrc[d] && (mPh[d] == 4'hF);
        if (mSrc[d]) mPh[d] <= mPh[d] + 1;
      end
    end
  end

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "count", count, mCnt);
    chk(tag, "reload", reload, mRld);
    chk(tag, "ovfFlag", {15'd0, ovfFlag}, {15'd0, mOvfF});
    chk(tag, "extFlag", {15'd0, extFlag}, {15'd0, mExtF});
    chk(tag, "irq", {15'd0, irq}, {15'd0, irqEn & (mOvfF | mExtF)});
    chk(tag, "rxTick", {15'd0, rxTick}, {15'd0, mTick[0]});
    chk(tag, "txTick", {15'd0, txTick}, {15'd0, mTick[1]});
    if (rxTick && prevRx) chk("R7", "rx tick width", 16'd2, 16'd1);
    if (txTick && prevTx) chk("R7", "tx tick width", 16'd2, 16'd1);
    prevRx = rxTick; prevTx = txTick;
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    checkAll(tag);
    cntWrEn = 0; rldWrEn = 0; ovfClr = 0; extClr = 0; altOvf = 0;
  endtask

  task automatic wrCnt(logic [W-1:0] v); cntWrEn = 1; cntWrData = v; endtask
  task automatic wrRld(logic [W-1:0] v); rldWrEn = 1; rldWrData = v; endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc("R11");                                  // reset state
    // R10: stopped counter holds
    wrCnt(16'h1234); cyc("R11");
    repeat (8) cyc("R10");
    // R1: non-baud reload mode, overflow reloads and sets flag (R12)
    irqEn = 1; wrRld(16'hFFF0); cyc("R11");
    wrCnt(16'hFFF8); run = 1; cyc("R1");
    repeat (40) cyc("R1");
    chk("R12", "ovfFlag set", {15'd0, ovfFlag}, 16'd1);
    ovfClr = 1; cyc("R11");
    // R12: capture mode wraps and captures on trigger
    captureMode = 1; extEnable = 1; wrCnt(16'hFFFC); cyc("R12");
    for (int i = 0; i < 40; i++) begin
      if (i % 9 == 4) trigPin = ~trigPin;
      cyc("R12");
    end
    extClr = 1; ovfClr = 1; cyc("R9");
    // R4 / R5 / R2: baud mode, capture bit ignored
    rxClkSel = 1; txClkSel = 1; wrRld(16'hFFF8); wrCnt(16'hFFF0); cyc("R4");
    for (int i = 0; i < 400; i++) begin
      if (i % 13 == 0) trigPin = ~trigPin;
      cyc(i < 50 ? "R5" : "R4");
      chk("R2", "no flag in baud", {15'd0, ovfFlag}, 16'd0);
    end
    // R3: receive from timer, transmit from alternate
    captureMode = 0; txClkSel = 0;
    for (int i = 0; i < 600; i++) begin
      altOvf = (i % 3 == 0);
      cyc("R3");
    end
    // R8: both from alternate, halved then bypassed
    rxClkSel = 0;
    for (int i = 0; i < 300; i++) begin
      doubleRate = (i >= 150);
      altOvf = (i % 2 == 0);
      cyc("R8");
    end
    // R6: external count pin in baud mode
    rxClkSel = 1; extCountSel = 1; wrCnt(16'hFFF0); cyc("R6");
    for (int i = 0; i < 600; i++) begin
      if (i % 3 == 0) cntPin = ~cntPin;
      cyc("R6");
    end
    // R9: trigger flag in baud mode with interrupt
    extCountSel = 0; irqEn = 1;
    for (int i = 0; i < 60; i++) begin
      trigPin = (i % 10 < 5);
      if (i == 30) extClr = 1;
      cyc("R9");
    end
    // random mix, writes colliding with advances (R11)
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        rxClkSel = $urandom_range(0, 1); txClkSel = $urandom_range(0, 1);
        extCountSel = $urandom_range(0, 1); captureMode = $urandom_range(0, 1);
        doubleRate = $urandom_range(0, 1);
      end
      run = ($urandom_range(0, 15) != 0);
      extEnable = $urandom_range(0, 1); irqEn = $urandom_range(0, 1);
      cntPin = $urandom_range(0, 1); trigPin = ($urandom_range(0, 3) != 0);
      altOvf = $urandom_range(0, 1);
      ovfClr = ($urandom_range(0, 7) == 0); extClr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 19) == 0) wrCnt(16'hFFF0 | 16'($urandom_range(0, 15)));
      if ($urandom_range(0, 29) == 0) wrRld(16'hFFE0 | 16'($urandom_range(0, 31)));
      @(negedge clk);
      checkAll("R11");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule